// File: doc/BRIEF.md
# Sprite Pixel Serializer with Collision Detection

This block turns up to four loaded sprite slots into a per-pixel sprite colour for a tile-based video pipeline. Each slot holds a signed horizontal start position, a 4-bit colour and a 16-bit pattern shift register. The line controller loads the slots one at a time during the sprite fetch window. During the line it then issues one step per horizontal slot. Each step evaluates two adjacent pixels, and the controller keeps stepping through the border, so the patterns stay aligned with the beam even where nothing is shown.

A slot does not start shifting until the beam reaches its start position. From then on it uses and shifts out one pattern bit per pixel. When several slots are opaque on the same pixel, the slot with the highest index supplies the colour. If an opaque slot lands on a pixel where a lower slot has already produced a non-zero colour, a collision is recorded.

The collision indicator is a two-state machine:
- `COLL_CLEAR` moves to `COLL_SEEN` on transition *detect* (a step with a coincidence).
- `COLL_SEEN` returns to `COLL_CLEAR` on transition *clear* (the clear pulse, with no coincidence in the same cycle).

A final priority mux lets a non-zero sprite colour override the background colour presented with each step.

Top module: `spr_serializer`

## Requirements
- R1: After reset, both sprite colours, both mixed colours and `collide` are 0, and all slots hold an all-zero pattern.
- R2: Loading a slot takes its colour from `load_tag[3:0]`. When `load_tag[7]` is 1, the start position is `load_x - 32`; otherwise it is `load_x`.
- R3: A loaded pattern is `{load_pat_hi, load_pat_lo}` when `wide_mode` is 1, and `{load_pat_hi, 8'h00}` otherwise. Bit 15 is emitted first.
- R4: A step evaluates pixels P and P+1, where P = 2*`hslot`. When 2*`hslot` exceeds 294, P = 2*`hslot` - 512 (a signed value).
- R5: A slot is active on a pixel when the pixel position is at or past its start position. On an active pixel it is opaque if its pattern MSB is 1, and its pattern then shifts left by one. An inactive slot neither emits nor shifts.
- R6: A pixel's sprite colour is the colour of the highest-index slot that is opaque on it, or 0 when no slot is opaque. The colour appears on `spr_col0`/`spr_col1` one clock after the step.
- R7: `collide` becomes 1 one clock after a step in which an opaque slot meets a non-zero colour from a lower-index slot on the same pixel. It then stays 1 until cleared. A lower slot whose colour is 0 causes no collision.
- R8: A `coll_clr` pulse returns `collide` to 0 on the next clock. If a collision is detected in the same cycle, the collision wins.
- R9: `mix_col0`/`mix_col1` show the sprite colour when it is non-zero; otherwise they show `bg_col0`/`bg_col1` as sampled at the step.
- R10: Without `step_en`, all colour outputs and all pattern positions hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Load strobe for one slot |
| load_slot | input | 2 | Index of the slot being loaded |
| load_x | input | 8 | Horizontal start position |
| load_tag | input | 8 | Bit 7 early shift, bits 3:0 colour |
| load_pat_hi | input | 8 | First pattern byte |
| load_pat_lo | input | 8 | Second pattern byte (used when wide) |
| wide_mode | input | 1 | 16-pixel sprite width select |
| step_en | input | 1 | Evaluate one pixel pair |
| hslot | input | 8 | Horizontal slot counter |
| bg_col0 | input | 4 | Background colour, first pixel |
| bg_col1 | input | 4 | Background colour, second pixel |
| coll_clr | input | 1 | Clear pulse for the collision flag |
| spr_col0 | output | 4 | Sprite colour, first pixel |
| spr_col1 | output | 4 | Sprite colour, second pixel |
| mix_col0 | output | 4 | Composited colour, first pixel |
| mix_col1 | output | 4 | Composited colour, second pixel |
| collide | output | 1 | Sticky collision flag |

## Verification
Collision detection and the collision clear pulse can fall in the same cycle. To provoke this, the bench loads two overlapping opaque slots and issues the step that makes them coincide while `coll_clr` is high. It then checks that `collide` reads 1 afterwards, and that a later clear with no coincidence brings it to 0. A second pairing is load against shift. A slot is reloaded between steps, and the next pixel pair must come from the fresh pattern, not from the shifted old one.

// File: rtl/spr_pkg.sv
`timescale 1ns/1ps
package spr_pkg;
    localparam int NUM_SLOTS   = 4;
    localparam int COL_W       = 4;
    localparam int BYTE_W      = 8;
    localparam int PAT_W       = 2 * BYTE_W;
    localparam int POS_W       = 11;
    localparam int EARLY_SHIFT = 32;

    typedef logic signed [POS_W-1:0] pos_t;

    typedef enum logic {
        COLL_CLEAR = 1'b0,
        COLL_SEEN  = 1'b1
    } coll_state_e;
endpackage

// File: rtl/spr_slot.sv
`timescale 1ns/1ps
module spr_slot
    import spr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [BYTE_W-1:0] ld_x,
    input  logic [BYTE_W-1:0] ld_tag,
    input  logic [BYTE_W-1:0] ld_hi,
    input  logic [BYTE_W-1:0] ld_lo,
    input  logic              wide,
    input  logic              step,
    input  pos_t              pos0,
    output logic              opq0,
    output logic              opq1,
    output logic [COL_W-1:0]  col
);
    pos_t             x_q;
    pos_t             pos1;
    logic [PAT_W-1:0] pat_q;
    logic [PAT_W-1:0] pat_mid;
    logic [PAT_W-1:0] pat_nxt;
    logic             act0;
    logic             act1;

    // Two pixels per step: the second sees the pattern after the first shift.
    always_comb begin
        pos1    = pos0 + pos_t'(1);
        act0    = (pos0 >= x_q);
        opq0    = act0 & pat_q[PAT_W-1];
        pat_mid = act0 ? {pat_q[PAT_W-2:0], 1'b0} : pat_q;
        act1    = (pos1 >= x_q);
        opq1    = act1 & pat_mid[PAT_W-1];
        pat_nxt = act1 ? {pat_mid[PAT_W-2:0], 1'b0} : pat_mid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= '0;
            pat_q <= '0;
            col   <= '0;
        end else if (ld) begin
            x_q   <= pos_t'(ld_x) - (ld_tag[BYTE_W-1] ? pos_t'(EARLY_SHIFT) : pos_t'(0));
            col   <= ld_tag[COL_W-1:0];
            pat_q <= {ld_hi, (wide ? ld_lo : {BYTE_W{1'b0}})};
        end else if (step) begin
            pat_q <= pat_nxt;
        end
    end
endmodule

// File: rtl/spr_pixel_arb.sv
`timescale 1ns/1ps
module spr_pixel_arb
    import spr_pkg::*;
#(
    parameter int N = NUM_SLOTS
) (
    input  logic [N-1:0]       opq,
    input  logic [N*COL_W-1:0] cols,
    output logic [COL_W-1:0]   col,
    output logic               hit
);
    // Walk slots in index order; a later opaque slot overrides the running colour.
    always_comb begin
        col = '0;
        hit = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (opq[i]) begin
                if (col != '0) hit = 1'b1;
                col = cols[i*COL_W +: COL_W];
            end
        end
    end
endmodule

// File: rtl/spr_serializer.sv
`timescale 1ns/1ps
module spr_serializer
    import spr_pkg::*;
#(
    parameter int HS_W     = 8,
    parameter int WRAP_AT  = 294,
    parameter int WRAP_SUB = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [1:0]       load_slot,
    input  logic [7:0]       load_x,
    input  logic [7:0]       load_tag,
    input  logic [7:0]       load_pat_hi,
    input  logic [7:0]       load_pat_lo,
    input  logic             wide_mode,
    input  logic             step_en,
    input  logic [HS_W-1:0]  hslot,
    input  logic [3:0]       bg_col0,
    input  logic [3:0]       bg_col1,
    input  logic             coll_clr,
    output logic [3:0]       spr_col0,
    output logic [3:0]       spr_col1,
    output logic [3:0]       mix_col0,
    output logic [3:0]       mix_col1,
    output logic             collide
);
    localparam int NPIX = 2;

    pos_t                       pos_raw;
    pos_t                       pos_cur;
    logic [NUM_SLOTS-1:0]       opq_v [NPIX];
    logic [NUM_SLOTS*COL_W-1:0] col_flat;
    logic [COL_W-1:0]           pix_col [NPIX];
    logic [NPIX-1:0]            pix_hit;
    logic                       hit_any;
    coll_state_e                state_q;
    coll_state_e                state_d;

    // Beam position: doubled slot count, folded negative near line start.
    always_comb begin
        pos_raw = pos_t'({hslot, 1'b0});
        pos_cur = (pos_raw > pos_t'(WRAP_AT)) ? pos_raw - pos_t'(WRAP_SUB) : pos_raw;
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        spr_slot u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (load_en && (load_slot == s[1:0])),
            .ld_x  (load_x),
            .ld_tag(load_tag),
            .ld_hi (load_pat_hi),
            .ld_lo (load_pat_lo),
            .wide  (wide_mode),
            .step  (step_en),
            .pos0  (pos_cur),
            .opq0  (opq_v[0][s]),
            .opq1  (opq_v[1][s]),
            .col   (col_flat[s*COL_W +: COL_W])
        );
    end

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        spr_pixel_arb #(.N(NUM_SLOTS)) u_arb (
            .opq (opq_v[p]),
            .cols(col_flat),
            .col (pix_col[p]),
            .hit (pix_hit[p])
        );
    end

    assign hit_any = step_en && (|pix_hit);

    // Collision state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= COLL_CLEAR;
        else        state_q <= state_d;
    end

    // Transitions: detect (CLEAR->SEEN), clear (SEEN->CLEAR); detect wins.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            COLL_CLEAR: if (hit_any)              state_d = COLL_SEEN;
            COLL_SEEN:  if (coll_clr && !hit_any) state_d = COLL_CLEAR;
        endcase
    end

    assign collide = (state_q == COLL_SEEN);

    // Pixel outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spr_col0 <= '0;
            spr_col1 <= '0;
            mix_col0 <= '0;
            mix_col1 <= '0;
        end else if (step_en) begin
            spr_col0 <= pix_col[0];
            spr_col1 <= pix_col[1];
            mix_col0 <= (pix_col[0] != '0) ? pix_col[0] : bg_col0;
            mix_col1 <= (pix_col[1] != '0) ? pix_col[1] : bg_col1;
        end
    end
endmodule

// File: rtl/spr_serializer_chk.sv
`timescale 1ns/1ps
module spr_serializer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       step_en,
    input logic       coll_clr,
    input logic       hit_any,
    input logic       collide,
    input logic [3:0] spr_col0,
    input logic [3:0] spr_col1
);
    assert_hold_col_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(spr_col0) && $stable(spr_col1)));

    assert_detect_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |=> collide);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (collide && !coll_clr) |=> collide);

    assert_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(collide) |-> $past(hit_any));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_clr && !step_en) |=> !collide);
endmodule

bind spr_serializer spr_serializer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .coll_clr(coll_clr),
    .hit_any (hit_any),
    .collide (collide),
    .spr_col0(spr_col0),
    .spr_col1(spr_col1)
);

// File: tb/spr_serializer_test.sv
`timescale 1ns/1ps
module spr_serializer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [1:0] load_slot = '0;
    logic [7:0] load_x = '0, load_tag = '0, load_pat_hi = '0, load_pat_lo = '0;
    logic       wide_mode = 1'b0;
    logic       step_en = 1'b0;
    logic [7:0] hslot = '0;
    logic [3:0] bg_col0 = '0, bg_col1 = '0;
    logic       coll_clr = 1'b0;
    logic [3:0] spr_col0, spr_col1, mix_col0, mix_col1;
    logic       collide;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    spr_serializer uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_slot(load_slot),
        .load_x(load_x), .load_tag(load_tag), .load_pat_hi(load_pat_hi),
        .load_pat_lo(load_pat_lo), .wide_mode(wide_mode), .step_en(step_en),
        .hslot(hslot), .bg_col0(bg_col0), .bg_col1(bg_col1), .coll_clr(coll_clr),
        .spr_col0(spr_col0), .spr_col1(spr_col1), .mix_col0(mix_col0),
        .mix_col1(mix_col1), .collide(collide)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_load(input int s, input int x, input int tag,
                           input int hi, input int lo, input bit wide);
        @(negedge clk);
        load_en = 1'b1; load_slot = 2'(s); load_x = 8'(x); load_tag = 8'(tag);
        load_pat_hi = 8'(hi); load_pat_lo = 8'(lo); wide_mode = wide;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic clear_all();
        for (int s = 0; s < 4; s++) do_load(s, 0, 0, 0, 0, 1'b0);
    endtask

    task automatic do_step(input int hs, input int b0, input int b1, input bit clr);
        @(negedge clk);
        step_en = 1'b1; hslot = 8'(hs); bg_col0 = 4'(b0); bg_col1 = 4'(b1); coll_clr = clr;
        @(negedge clk);
        step_en = 1'b0; coll_clr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        coll_clr = 1'b1;
        @(negedge clk);
        coll_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 spr_col0", spr_col0, 0);
        chk("R1 spr_col1", spr_col1, 0);
        chk("R1 mix_col0", mix_col0, 0);
        chk("R1 collide", collide, 0);
        do_step(5, 0, 0, 1'b0);
        chk("R1 empty slots emit nothing", spr_col0 + spr_col1, 0);
    endtask

    task automatic t_start_and_mix();
        clear_all();
        do_load(0, 10, 8'h05, 8'hA0, 0, 1'b0);
        do_step(4, 3, 3, 1'b0);
        chk("R5 before start c0", spr_col0, 0);
        chk("R9 bg passes c0", mix_col0, 3);
        do_step(5, 3, 3, 1'b0);
        chk("R5 first px c0", spr_col0, 5);
        chk("R5 first px c1", spr_col1, 0);
        chk("R9 sprite overrides", mix_col0, 5);
        chk("R9 bg on gap", mix_col1, 3);
        do_step(6, 0, 0, 1'b0);
        chk("R5 third px", spr_col0, 5);
        do_step(7, 0, 0, 1'b0);
        chk("R5 drained", spr_col0, 0);
        do_load(0, 11, 8'h05, 8'h80, 0, 1'b0);
        do_step(5, 0, 0, 1'b0);
        chk("R5 straddle c0", spr_col0, 0);
        chk("R5 straddle c1", spr_col1, 5);
    endtask

    task automatic t_width();
        clear_all();
        do_load(2, 0, 8'h07, 8'h00, 8'hFF, 1'b1);
        for (int h = 0; h < 4; h++) do_step(h, 0, 0, 1'b0);
        chk("R3 wide upper half blank", spr_col0, 0);
        do_step(4, 0, 0, 1'b0);
        chk("R3 wide lower half c0", spr_col0, 7);
        chk("R3 wide lower half c1", spr_col1, 7);
        do_load(2, 0, 8'h07, 8'h00, 8'hFF, 1'b0);
        for (int h = 0; h < 5; h++) do_step(h, 0, 0, 1'b0);
        chk("R3 narrow lower half zero", spr_col0, 0);
    endtask

    task automatic t_early_and_wrap();
        clear_all();
        do_load(1, 40, 8'h89, 8'hC0, 0, 1'b0);
        do_step(4, 0, 0, 1'b0);
        chk("R2 early shift c0", spr_col0, 9);
        chk("R2 early shift c1", spr_col1, 9);
        do_load(1, 0, 8'h82, 8'hC0, 0, 1'b0);
        do_step(148, 0, 0, 1'b0);
        chk("R4 wrap leaves -216 before start", spr_col0, 0);
        do_step(240, 0, 0, 1'b0);
        chk("R4 wrap -32 c0", spr_col0, 2);
        chk("R4 wrap -31 c1", spr_col1, 2);
        do_load(1, 200, 8'h04, 8'h80, 0, 1'b0);
        do_step(147, 0, 0, 1'b0);
        chk("R4 294 not folded", spr_col0, 4);
    endtask

    task automatic t_collision();
        clear_all();
        pulse_clr();
        do_load(0, 20, 8'h03, 8'hC0, 0, 1'b0);
        do_load(1, 21, 8'h06, 8'h80, 0, 1'b0);
        do_step(10, 0, 0, 1'b0);
        chk("R6 low slot alone", spr_col0, 3);
        chk("R6 high slot wins", spr_col1, 6);
        chk("R7 collision set", collide, 1);
        do_step(30, 0, 0, 1'b0);
        chk("R7 sticky", collide, 1);
        pulse_clr();
        chk("R8 clear", collide, 0);
        do_load(0, 20, 8'h03, 8'hC0, 0, 1'b0);
        do_load(1, 21, 8'h06, 8'h80, 0, 1'b0);
        do_step(10, 0, 0, 1'b1);
        chk("R8 detect beats clear", collide, 1);
        pulse_clr();
        chk("R8 clear after tie", collide, 0);
        do_load(0, 20, 8'h00, 8'hC0, 0, 1'b0);
        do_load(1, 21, 8'h06, 8'h80, 0, 1'b0);
        do_step(10, 0, 0, 1'b0);
        chk("R7 zero-colour lower slot no collision", collide, 0);
        chk("R6 colour-0 slot yields 0", spr_col0, 0);
    endtask

    task automatic t_hold();
        clear_all();
        do_load(3, 0, 8'h05, 8'hA0, 0, 1'b0);
        do_step(0, 0, 0, 1'b0);
        chk("R10 pre-hold c0", spr_col0, 5);
        @(negedge clk); hslot = 8'd90;
        repeat (3) @(negedge clk);
        chk("R10 held c0", spr_col0, 5);
        chk("R10 held c1", spr_col1, 0);
        do_step(1, 0, 0, 1'b0);
        chk("R10 pattern did not shift", spr_col0, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_and_mix();
        t_width();
        t_early_and_wrap();
        t_collision();
        t_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule